// File: doc/BRIEF.md
# Slot-Coded Anticollision Arbitration Responder

This block is the tag-side half of a bitwise tree search over a 32-bit unique identifier. After a start-arbitration command, the tag walks its identifier from the least significant bit upward. For each bit it returns one reply frame of six equal time slots. The value of the bit is carried by where in the frame the tag modulates, not by the level it sends. A zero uses the two leading slots and a one uses the two trailing slots, so any number of tags can answer at once without corrupting each other.

Between frames the reader broadcasts a two-bit continue decision. A tag whose last bit agrees with it keeps going, and any other tag drops out until a new command arrives. The tag that survives the decision on its top bit marks itself as read-enabled. It then sends a CRC-8 over its identifier and that flag, one bit per reply frame, using the same slot coding.

Upstream logic delivers frames that have been demodulated and CRC-checked, together with one strobe per carrier period. The block answers with a per-cycle modulation request.

Top module: `arb_responder`

## Requirements
- R1: After reset `rd_en`, `mod_on` and `in_arb` are all 0.
- R2: A command with opcode 4'b0001 (start arbitration) opens a session only while `rd_en` is 0. With `rd_en` at 1 it is ignored: `in_arb` stays 0 and no modulation follows.
- R3: The first reply slot starts `GAP_CMD` carrier ticks after the edge that accepts a start or a confirming continue. Each slot lasts `SLOT_LEN` ticks.
- R4: In a reply frame, a bit of 0 modulates slots 0 and 1 and a bit of 1 modulates slots 4 and 5. Slots 2 and 3 are never modulated.
- R5: Identifier bits are sent least significant first, one frame per confirming continue.
- R6: A continue of 2'b00 while the last sent bit is 0, or 2'b11 while it is 1, starts the next frame. The opposite code makes the tag leave the session (`in_arb` = 0, no further modulation).
- R7: A continue of 2'b01 or 2'b10 ends the session.
- R8: Any command with an opcode other than 4'b0001 ends the session.
- R9: A confirming continue on the top identifier bit sets `rd_en` to 1, which then stays set until reset. The tag then sends 8 CRC frames, most significant CRC bit first, each starting `GAP_PHASE` ticks after the previous frame ends (or after the continue, for the first). The CRC uses polynomial x^8+x^7+x^5+x^4+x+1 (0xB3 with implicit x^8) and starts from 0. It is computed over the identifier bits, least significant first, followed by a single 1 for the flag.
- R10: A start command during a session, while `rd_en` is 0, restarts the session from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| car_tick | input | 1 | One-cycle strobe per carrier period |
| cmd_valid | input | 1 | A full, CRC-checked reader command is present this cycle |
| cmd_op | input | 4 | Opcode of that command |
| cont_valid | input | 1 | A continue frame is present this cycle |
| cont_bits | input | 2 | Two-bit continue decision |
| tag_id | input | 32 | Unique identifier of this tag |
| mod_on | output | 1 | Load-modulate during this cycle |
| rd_en | output | 1 | Read-enable flag (1 = already identified) |
| in_arb | output | 1 | Tag is taking part in an arbitration session |

## Verification
The assertions assume that `cmd_valid` and `cont_valid` are single-cycle pulses and that a continue decision arrives together with a command only when it should lose to that command. They also assume `tag_id` is held steady across a session. The stimulus honours this. Every frame is driven for exactly one cycle from the falling edge, continues are sent only once the reference model reports the tag waiting for a decision, and the identifier is a fixed constant. Carrier strobes are sometimes on every clock and sometimes on alternate clocks, so that slot timing is checked independently of the clock rate.

// File: rtl/arb_pkg.sv
// Shared constants and types for the arbitration responder.
// Assumes a 4-bit command opcode field and a CRC-8 with implicit x^8.
package arb_pkg;
    localparam logic [3:0] OP_START_ARB = 4'b0001;
    localparam logic [7:0] CRC_POLY     = 8'hB3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_SEND = 2'd2,
        ST_HOLD = 2'd3
    } arb_state_e;
endpackage

// File: rtl/arb_tick_timer.sv
// Counts carrier ticks and pulses `expire` on the tick that completes a
// programmed length. It restarts by itself after each expiry, so repeated
// equal slots need no reload. Assumes len >= 1.
module arb_tick_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;

    // Expiry on the tick that finishes the programmed length.
    assign expire = tick && (cnt_q == len_q - CNT_W'(1));

    // Tick counter with reload and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= CNT_W'(1);
        end else if (load) begin
            cnt_q <= '0;
            len_q <= len;
        end else if (expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/arb_slot_gen.sv
// Tracks the slot position inside one reply frame and decides whether the
// current slot is modulated. EDGE slots at the head carry a 0, EDGE slots
// at the tail carry a 1. Assumes 2*EDGE < SLOTS.
module arb_slot_gen #(
    parameter int SLOTS  = 6,
    parameter int EDGE   = 2,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              sending,
    input  logic              bit_val,
    output logic [SLOT_W-1:0] slot,
    output logic              last,
    output logic              mod
);
    logic [SLOTS-1:0] head_mask;
    logic [SLOTS-1:0] tail_mask;

    // Build the slot masks for the two bit values.
    for (genvar g = 0; g < SLOTS; g++) begin : g_mask
        assign head_mask[g] = (g < EDGE);
        assign tail_mask[g] = (g >= SLOTS - EDGE);
    end

    assign last = (slot == SLOT_W'(SLOTS - 1));
    assign mod  = sending && (bit_val ? tail_mask[slot] : head_mask[slot]);

    // Slot position register.
    always_ff @(posedge clk) begin
        if (!rst_n)      slot <= '0;
        else if (clear)  slot <= '0;
        else if (step)   slot <= slot + SLOT_W'(1);
    end
endmodule

// File: rtl/arb_crc8.sv
// Combinational CRC-8 over the identifier (LSB first) followed by a single
// 1 for the read-enable flag. Register starts at 0, MSB-feedback form.
module arb_crc8 #(
    parameter int ID_W = 32
) (
    input  logic [ID_W-1:0] id,
    output logic [7:0]      crc
);
    import arb_pkg::*;

    // Serial CRC unrolled over ID_W+1 input bits.
    always_comb begin
        logic [7:0] c;
        logic       fb;
        c = '0;
        for (int i = 0; i < ID_W; i++) begin
            fb = c[7] ^ id[i];
            c  = {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
        end
        fb  = c[7] ^ 1'b1;
        crc = {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    end
endmodule

// File: rtl/arb_responder.sv
// Tag-side arbitration responder. Walks the identifier LSB first and sends
// one slot-coded frame per bit. It waits for the reader's continue decision
// between frames, and on surviving the top bit sets rd_en and sends a CRC-8
// as eight further frames. Assumes single-cycle command/continue pulses
// from a demodulator that has already checked frame CRCs, and one car_tick
// per carrier period.
module arb_responder #(
    parameter int ID_W      = 32,
    parameter int SLOT_LEN  = 32,
    parameter int GAP_CMD   = 62,
    parameter int GAP_PHASE = 10,
    parameter int SLOTS     = 6,
    parameter int EDGE      = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            car_tick,
    input  logic            cmd_valid,
    input  logic [3:0]      cmd_op,
    input  logic            cont_valid,
    input  logic [1:0]      cont_bits,
    input  logic [ID_W-1:0] tag_id,
    output logic            mod_on,
    output logic            rd_en,
    output logic            in_arb
);
    import arb_pkg::*;

    localparam int CRC_W   = 8;
    localparam int MAX_A   = (SLOT_LEN > GAP_CMD) ? SLOT_LEN : GAP_CMD;
    localparam int MAX_LEN = (MAX_A > GAP_PHASE) ? MAX_A : GAP_PHASE;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam int IDX_W   = $clog2(ID_W);
    localparam int SLOT_W  = $clog2(SLOTS);

    arb_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic              crc_ph_q, crc_ph_d;
    logic              rd_en_q, rd_en_d;
    logic [CRC_W-1:0]  crc_q, crc_d;
    logic [CRC_W-1:0]  crc_calc;

    logic              t_load, t_expire;
    logic [CNT_W-1:0]  t_len;
    logic              s_clear, s_step, s_last;
    logic [SLOT_W-1:0] slot_idx;
    logic              cur_bit, cont_ok, sending;

    assign cur_bit = crc_ph_q ? crc_q[CRC_W-1] : tag_id[idx_q];
    assign cont_ok = (cont_bits == 2'b00 && !cur_bit) ||
                     (cont_bits == 2'b11 &&  cur_bit);
    assign sending = (state_q == ST_SEND);

    arb_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (t_load),
        .len    (t_len),
        .tick   (car_tick),
        .expire (t_expire)
    );

    arb_slot_gen #(.SLOTS(SLOTS), .EDGE(EDGE), .SLOT_W(SLOT_W)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (s_clear),
        .step    (s_step),
        .sending (sending),
        .bit_val (cur_bit),
        .slot    (slot_idx),
        .last    (s_last),
        .mod     (mod_on)
    );

    arb_crc8 #(.ID_W(ID_W)) u_crc (
        .id  (tag_id),
        .crc (crc_calc)
    );

    // Next-state decision: commands beat continues, continues beat timing.
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        crc_ph_d = crc_ph_q;
        rd_en_d  = rd_en_q;
        crc_d    = crc_q;
        t_load   = 1'b0;
        t_len    = CNT_W'(GAP_CMD);
        s_clear  = 1'b0;
        s_step   = 1'b0;
        if (cmd_valid) begin
            if (cmd_op == OP_START_ARB && !rd_en_q) begin
                state_d  = ST_GAP;
                idx_d    = '0;
                crc_ph_d = 1'b0;
                t_load   = 1'b1;
            end else begin
                state_d = ST_IDLE;
            end
        end else if (cont_valid) begin
            if (state_q == ST_HOLD && cont_ok) begin
                state_d = ST_GAP;
                t_load  = 1'b1;
                if (idx_q == IDX_W'(ID_W - 1)) begin
                    rd_en_d  = 1'b1;
                    crc_ph_d = 1'b1;
                    idx_d    = '0;
                    crc_d    = crc_calc;
                    t_len    = CNT_W'(GAP_PHASE);
                end else begin
                    idx_d = idx_q + IDX_W'(1);
                end
            end else begin
                state_d = ST_IDLE;
            end
        end else if (t_expire) begin
            case (state_q)
                ST_GAP: begin
                    state_d = ST_SEND;
                    s_clear = 1'b1;
                    t_load  = 1'b1;
                    t_len   = CNT_W'(SLOT_LEN);
                end
                ST_SEND: begin
                    if (!s_last) begin
                        s_step = 1'b1;
                    end else if (!crc_ph_q) begin
                        state_d = ST_HOLD;
                    end else if (idx_q == IDX_W'(CRC_W - 1)) begin
                        state_d = ST_IDLE;
                    end else begin
                        idx_d   = idx_q + IDX_W'(1);
                        crc_d   = crc_q << 1;
                        state_d = ST_GAP;
                        t_load  = 1'b1;
                        t_len   = CNT_W'(GAP_PHASE);
                    end
                end
                default: ;
            endcase
        end
    end

    // Session state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            crc_ph_q <= 1'b0;
            rd_en_q  <= 1'b0;
            crc_q    <= '0;
        end else begin
            state_q  <= state_d;
            idx_q    <= idx_d;
            crc_ph_q <= crc_ph_d;
            rd_en_q  <= rd_en_d;
            crc_q    <= crc_d;
        end
    end

    assign rd_en  = rd_en_q;
    assign in_arb = (state_q != ST_IDLE);
endmodule

// File: rtl/arb_responder_chk.sv
// Property checker for arb_responder, attached by bind. Assumes
// single-cycle command and continue pulses.
module arb_responder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [3:0] cmd_op,
    input logic       cont_valid,
    input logic [1:0] cont_bits,
    input logic       mod_on,
    input logic       rd_en,
    input logic       in_arb,
    input logic [2:0] slot
);
    AST_MID_SLOTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mod_on |-> (slot != 3'd2 && slot != 3'd3)); // R4

    AST_MOD_NEEDS_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
        mod_on |-> in_arb); // R6

    AST_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'b0001 && rd_en) |=> !in_arb); // R2

    AST_START_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'b0001 && !rd_en) |=> in_arb); // R10

    AST_ABORT_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_valid && !cmd_valid && (cont_bits[1] ^ cont_bits[0])) |=> !in_arb); // R7

    AST_OTHER_CMD_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op != 4'b0001) |=> !in_arb); // R8

    AST_RDEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(rd_en)); // R9

    AST_RDEN_SET_IN_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> in_arb); // R9
endmodule

bind arb_responder arb_responder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cont_valid (cont_valid),
    .cont_bits  (cont_bits),
    .mod_on     (mod_on),
    .rd_en      (rd_en),
    .in_arb     (in_arb),
    .slot       (slot_idx)
);

// File: tb/arb_responder_test.sv
module arb_responder_test;
    localparam int GAP_CMD = 62;
    localparam int GAP_PH  = 10;
    localparam int SLEN    = 32;
    localparam logic [31:0] ID = 32'hA5C3_0F96;

    logic clk = 0, rst_n = 0, car_tick = 1;
    logic cmd_valid = 0, cont_valid = 0;
    logic [3:0] cmd_op = 0;
    logic [1:0] cont_bits = 0;
    logic mod_on, rd_en, in_arb;
    int n_tests = 0, n_fail = 0;
    bit half_rate = 0, done = 0;

    always #2.5 clk = ~clk;

    arb_responder uut (
        .clk(clk), .rst_n(rst_n), .car_tick(car_tick),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cont_valid(cont_valid), .cont_bits(cont_bits),
        .tag_id(ID), .mod_on(mod_on), .rd_en(rd_en), .in_arb(in_arb)
    );

    // Reference CRC: long division over the message bit stream.
    function automatic logic [7:0] ref_crc(input logic [31:0] id);
        logic [8:0] r;
        logic       b;
        r = '0;
        for (int k = 0; k < 33; k++) begin
            b = (k < 32) ? id[k] : 1'b1;
            r = {r[7:0], 1'b0};
            if (r[8] ^ b) r = r ^ 9'h1B3;
            r[8] = 1'b0;
        end
        return r[7:0];
    endfunction

    // Behavioural model: 0 idle, 1 waiting, 2 sending, 3 awaiting decision.
    int m_st = 0, m_rem = 0, m_slot = 0, m_idx = 0;
    bit m_crc_ph = 0, m_rd = 0;
    logic [7:0] m_crc = 0;

    function automatic bit m_bit();
        return m_crc_ph ? m_crc[7] : ID[m_idx];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_rd = 0; m_crc_ph = 0; m_idx = 0;
        end else if (cmd_valid) begin
            if (cmd_op == 4'b0001 && !m_rd) begin
                m_st = 1; m_rem = GAP_CMD; m_idx = 0; m_crc_ph = 0;
            end else m_st = 0;
        end else if (cont_valid) begin
            if (m_st == 3 && ((cont_bits == 2'b00 && !m_bit()) || (cont_bits == 2'b11 && m_bit()))) begin
                m_st = 1;
                if (m_idx == 31) begin
                    m_rd = 1; m_crc_ph = 1; m_idx = 0; m_crc = ref_crc(ID); m_rem = GAP_PH;
                end else begin
                    m_idx++; m_rem = GAP_CMD;
                end
            end else m_st = 0;
        end else if (car_tick && (m_st == 1 || m_st == 2)) begin
            m_rem--;
            if (m_rem == 0) begin
                if (m_st == 1) begin
                    m_st = 2; m_slot = 0; m_rem = SLEN;
                end else if (m_slot < 5) begin
                    m_slot++; m_rem = SLEN;
                end else if (!m_crc_ph) m_st = 3;
                else if (m_idx == 7) m_st = 0;
                else begin
                    m_idx++; m_crc = m_crc << 1; m_st = 1; m_rem = GAP_PH;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_mod;
            exp_mod = (m_st == 2) && (m_bit() ? (m_slot >= 4) : (m_slot <= 1));
            check(mod_on == exp_mod, m_crc_ph ? "R9 mod_on in CRC frame" : "R4 R5 mod_on in ID frame",
                  int'(mod_on), int'(exp_mod));
            check(rd_en == m_rd, "R9 rd_en", int'(rd_en), int'(m_rd));
            check(in_arb == (m_st != 0), "R6 in_arb", int'(in_arb), int'(m_st != 0));
        end
    end

    // Carrier strobe: every cycle, or every other cycle in half-rate mode.
    always @(negedge clk) car_tick <= half_rate ? ~car_tick : 1'b1;

    task automatic send_cmd(input logic [3:0] op);
        @(negedge clk); cmd_valid = 1; cmd_op = op;
        @(negedge clk); cmd_valid = 0;
    endtask

    task automatic send_cont(input logic [1:0] b);
        @(negedge clk); cont_valid = 1; cont_bits = b;
        @(negedge clk); cont_valid = 0;
    endtask

    task automatic wait_hold();
        while (m_st != 3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wait_cycles_for_mod(output int n);
        n = 1;
        while (!mod_on && n < 2000) begin @(negedge clk); n++; end
    endtask

    initial begin
        int n;
        int run;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rd_en == 0, "R1 rd_en after reset", int'(rd_en), 0);
        check(mod_on == 0, "R1 mod_on after reset", int'(mod_on), 0);
        check(in_arb == 0, "R1 in_arb after reset", int'(in_arb), 0);
        rst_n = 1;

        // R3: first slot after GAP_CMD ticks; R4: slot 0..1 run for bit 0
        send_cmd(4'b0001);
        wait_cycles_for_mod(n);
        check(n == GAP_CMD + 1, "R3 start-to-first-slot latency", n, GAP_CMD + 1);
        run = 0;
        while (mod_on) begin run++; @(negedge clk); end
        check(run == 2 * SLEN, "R4 modulated run for bit 0", run, 2 * SLEN);

        // R5: second frame carries ID bit 1 (=1), first modulation in slot 4
        wait_hold();
        send_cont(2'b00);
        wait_cycles_for_mod(n);
        check(n == GAP_CMD + 4 * SLEN + 1, "R5 second frame carries bit 1 in tail slots",
              n, GAP_CMD + 4 * SLEN + 1);

        // R10: restart mid-session
        wait_hold();
        send_cont(2'b11);
        wait_hold();
        send_cmd(4'b0001);
        check(in_arb == 1, "R10 in_arb after restart", int'(in_arb), 1);
        wait_cycles_for_mod(n);
        check(n == GAP_CMD + 1, "R10 restart begins again at bit 0", n, GAP_CMD + 1);

        // R6: mismatching decision (bit 0 is 0, decision 11)
        wait_hold();
        send_cont(2'b11);
        check(in_arb == 0, "R6 drop on mismatch", int'(in_arb), 0);
        repeat (300) @(negedge clk);
        check(mod_on == 0, "R6 silent after drop", int'(mod_on), 0);

        // R7: abort code
        send_cmd(4'b0001);
        wait_hold();
        send_cont(2'b10);
        check(in_arb == 0, "R7 abort with 10", int'(in_arb), 0);
        send_cmd(4'b0001);
        wait_hold();
        send_cont(2'b01);
        check(in_arb == 0, "R7 abort with 01", int'(in_arb), 0);

        // R8: other opcode mid-session, at half carrier rate
        half_rate = 1;
        send_cmd(4'b0001);
        wait_hold();
        send_cont(2'b00);
        repeat (50) @(negedge clk);
        send_cmd(4'b0101);
        check(in_arb == 0, "R8 leave on other command", int'(in_arb), 0);
        half_rate = 0;
        repeat (4) @(negedge clk);

        // R9: full session to the end, then CRC frames
        send_cmd(4'b0001);
        for (int i = 0; i < 32; i++) begin
            wait_hold();
            send_cont(ID[i] ? 2'b11 : 2'b00);
        end
        check(rd_en == 1, "R9 rd_en set after last bit", int'(rd_en), 1);
        while (in_arb) @(negedge clk);
        check(rd_en == 1, "R9 rd_en held after CRC", int'(rd_en), 1);

        // R2: start ignored while rd_en is 1
        send_cmd(4'b0001);
        check(in_arb == 0, "R2 start ignored with rd_en set", int'(in_arb), 0);
        run = 0;
        for (int k = 0; k < 300; k++) begin @(negedge clk); if (mod_on) run++; end
        check(run == 0, "R2 no modulation when ignored", run, 0);

        // R1: reset clears the flag
        do_reset();
        @(negedge clk);
        check(rd_en == 0, "R1 rd_en cleared by reset", int'(rd_en), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R9 watchdog act=running exp=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule